// File: doc/BRIEF.md
# Receiver Error Status and Packet-Drop Controller

This block gathers the per-packet error indications of a camera-serial receiver and holds each one as a sticky status bit. Software reads the bits through a small register port and clears them by writing ones. A separate read/write enable register gates the bits onto a single interrupt line. The error strobes come from three places: the lane layer, the packet-header checker and the payload CRC checker. Each strobe is one cycle wide.

Most errors are only logged. Two of them abort the packet being received. A synchronization failure at the start of transmission makes the packet unusable. A two-bit header ECC error leaves the word count untrustworthy, so the packet end cannot be located. When either occurs, the block raises a drop flag and holds it until the next packet-start marker. While the flag is up, the payload stream that passes through the block is discarded. The upstream side keeps draining and nothing reaches downstream.

The payload passes through as a valid/ready stream. A beat moves when valid and ready are both high on a clock edge. Outside a drop, ready toward the source is a copy of the downstream ready, so back-pressure passes straight through. During a drop, ready toward the source is forced high, so the source is never stalled by a packet that is being thrown away.

Top module: `rxerr_ctrl`

## Requirements
- R1: After reset, all status bits, the enable register, `irq` and `drop` are 0.
- R2: Event bit positions are fixed as follows: 0 CRC mismatch, 1 corrected single-bit header ECC, 2 two-bit header ECC, 3 start-of-transmission soft error, 4 start-of-transmission sync error, 5 lane control error, 6 escape-entry error, 7 ultra-low-power escape, 8 stop state. A strobe on `evt_in[i]` sets status bit i on the next clock edge, and the bit then stays set.
- R3: A write with `reg_addr`=0 clears every status bit whose `reg_wdata` bit is 1. Bits written with 0 keep their value.
- R4: When a strobe and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R5: A write with `reg_addr`=1 loads the enable register from `reg_wdata`.
- R6: `reg_rdata` shows the status register when `reg_addr`=0 and the enable register when `reg_addr`=1, without delay.
- R7: `irq` is high exactly when some status bit and the matching enable bit are both 1.
- R8: A strobe on bit 2 or bit 4 raises `drop` on the next edge. `drop` then stays high until a cycle with `pkt_start` high.
- R9: Strobes on bits 0, 1, 3, 5, 6, 7 and 8 never change `drop`.
- R10: `pkt_start` lowers `drop` on the next edge. If an aborting strobe arrives in the same cycle, `drop` goes high instead.
- R11: While `drop` is low, `out_valid`=`in_valid`, `out_data`=`in_data` and `in_ready`=`out_ready`. While `drop` is high, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | 9 | Single-cycle error and condition strobes (positions per R2) |
| pkt_start | input | 1 | Packet-start marker |
| pkt_end | input | 1 | Packet-end marker (carried to the stream as the last-beat flag) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects status, 1 selects enable |
| reg_wdata | input | 9 | Write data |
| reg_rdata | output | 9 | Read data for the selected register |
| irq | output | 1 | Interrupt request |
| drop | output | 1 | Current packet is being discarded |
| in_valid | input | 1 | Payload beat valid from the parser |
| in_ready | output | 1 | Payload beat accepted |
| in_data | input | 8 | Payload beat |
| out_valid | output | 1 | Payload beat valid downstream |
| out_ready | input | 1 | Downstream ready |
| out_data | output | 8 | Payload beat downstream |
| out_last | output | 1 | Beat coincides with the packet-end marker |

## Verification
The bench strobes every event bit one at a time. For each bit it checks which status bit was set and whether the drop flag followed. A design with an abort mask that is wrong would raise or miss a drop on the wrong class of error. It then clears each bit in the same cycle as a new strobe on that bit. A design that gives the clear priority would lose the error. It also checks the `pkt_start` and abort collision, where a design with the wrong priority would stream the corrupt packet. Finally, it sweeps all 512 enable masks against two status patterns, which exposes a mis-gated or inverted interrupt. It also walks every valid/ready combination with drop both high and low, which catches leaks of payload during a drop and a stalled source.

// File: rtl/rxerr_pkg.sv
package rxerr_pkg;
  localparam int EVT_W     = 9;
  localparam int B_CRC     = 0;
  localparam int B_ECC1    = 1;
  localparam int B_ECC2    = 2;
  localparam int B_SOT     = 3;
  localparam int B_SOTSYNC = 4;
  localparam int B_CTRL    = 5;
  localparam int B_ESC     = 6;
  localparam int B_ULPS    = 7;
  localparam int B_STOP    = 8;

  typedef logic [EVT_W-1:0] evt_t;

  localparam evt_t ABORT_MASK = evt_t'((1 << B_ECC2) | (1 << B_SOTSYNC));

  typedef enum logic {SEL_STATUS = 1'b0, SEL_ENABLE = 1'b1} reg_sel_e;
endpackage

// File: rtl/rxerr_sticky.sv
module rxerr_sticky #(
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q_o[i] <= 1'b0;
      else if (set_i[i])
        q_o[i] <= 1'b1;
      else if (clr_i[i])
        q_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/rxerr_drop_ctl.sv
module rxerr_drop_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic abort_i,
  input  logic start_i,
  output logic drop_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      drop_o <= 1'b0;
    else if (abort_i)
      drop_o <= 1'b1;
    else if (start_i)
      drop_o <= 1'b0;
  end
endmodule

// File: rtl/rxerr_stream_gate.sv
module rxerr_stream_gate #(
  parameter int DATA_W = 8
) (
  input  logic              drop_i,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_last,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic              m_last
);
  always_comb begin
    m_valid = s_valid & ~drop_i;
    s_ready = drop_i | m_ready;
    m_data  = s_data;
    m_last  = s_last & ~drop_i;
  end
endmodule

// File: rtl/rxerr_ctrl.sv
module rxerr_ctrl
  import rxerr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EVT_W-1:0]  evt_in,
  input  logic              pkt_start,
  input  logic              pkt_end,
  input  logic              reg_we,
  input  logic              reg_addr,
  input  logic [EVT_W-1:0]  reg_wdata,
  output logic [EVT_W-1:0]  reg_rdata,
  output logic              irq,
  output logic              drop,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last
);
  evt_t status_q;
  evt_t enable_q;
  evt_t clr_vec;
  logic abort_evt;

  assign clr_vec   = (reg_we && reg_sel_e'(reg_addr) == SEL_STATUS) ? reg_wdata : '0;
  assign abort_evt = |(evt_in & ABORT_MASK);

  rxerr_sticky #(.WIDTH(EVT_W)) u_sticky (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (evt_in),
    .clr_i (clr_vec),
    .q_o   (status_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      enable_q <= '0;
    else if (reg_we && reg_sel_e'(reg_addr) == SEL_ENABLE)
      enable_q <= reg_wdata;
  end

  always_comb begin
    case (reg_sel_e'(reg_addr))
      SEL_STATUS: reg_rdata = status_q;
      default:    reg_rdata = enable_q;
    endcase
  end

  assign irq = |(status_q & enable_q);

  rxerr_drop_ctl u_drop (
    .clk     (clk),
    .rst_n   (rst_n),
    .abort_i (abort_evt),
    .start_i (pkt_start),
    .drop_o  (drop)
  );

  rxerr_stream_gate #(.DATA_W(DATA_W)) u_gate (
    .drop_i  (drop),
    .s_valid (in_valid),
    .s_ready (in_ready),
    .s_data  (in_data),
    .s_last  (pkt_end),
    .m_valid (out_valid),
    .m_ready (out_ready),
    .m_data  (out_data),
    .m_last  (out_last)
  );
endmodule

// File: rtl/rxerr_ctrl_chk.sv
module rxerr_ctrl_chk
  import rxerr_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [8:0] evt_in,
  input logic       pkt_start,
  input logic       reg_we,
  input logic       reg_addr,
  input logic [8:0] reg_wdata,
  input logic [8:0] status_q,
  input logic [8:0] enable_q,
  input logic       irq,
  input logic       drop,
  input logic       in_ready,
  input logic       out_valid
);
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && !reg_addr) |=> ((status_q & $past(status_q)) == $past(status_q))); // R2
  AST_CLEAR_W1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !reg_addr) |=> ((status_q & $past(reg_wdata & ~evt_in)) == 9'd0)); // R3
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_in != 9'd0) |=> ((status_q & $past(evt_in)) == $past(evt_in))); // R4
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & enable_q) == 9'd0) |-> !irq); // R7
  AST_DROP_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_in[B_ECC2] || evt_in[B_SOTSYNC]) |=> drop); // R8
  AST_DROP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !pkt_start) |=> drop); // R8
  AST_DROP_CALM: assert property (@(posedge clk) disable iff (!rst_n)
    (!drop && !evt_in[B_ECC2] && !evt_in[B_SOTSYNC]) |=> !drop); // R9
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_start && !evt_in[B_ECC2] && !evt_in[B_SOTSYNC]) |=> !drop); // R10
  AST_GATE_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
    drop |-> (!out_valid && in_ready)); // R11
endmodule

bind rxerr_ctrl rxerr_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .evt_in    (evt_in),
  .pkt_start (pkt_start),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .status_q  (status_q),
  .enable_q  (enable_q),
  .irq       (irq),
  .drop      (drop),
  .in_ready  (in_ready),
  .out_valid (out_valid)
);

// File: tb/sim_rxerr_ctrl.sv
`timescale 1ns/1ps
module sim_rxerr_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] evt_in = '0;
  logic       pkt_start = 1'b0;
  logic       pkt_end = 1'b0;
  logic       reg_we = 1'b0;
  logic       reg_addr = 1'b0;
  logic [8:0] reg_wdata = '0;
  logic [8:0] reg_rdata;
  logic       irq, drop;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [7:0] out_data;
  logic       out_last;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  rxerr_ctrl u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic pulse_evt(input logic [8:0] v);
    evt_in = v; step(); evt_in = '0;
  endtask

  task automatic wr(input logic a, input logic [8:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d; step(); reg_we = 1'b0;
  endtask

  function automatic logic [8:0] rd(input logic a);
    return '0;
  endfunction

  task automatic read_reg(input logic a, output logic [8:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic restart();
    rst_n = 1'b0; step(); rst_n = 1'b1; step();
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [8:0] v;
    logic [8:0] pats [2];
    step(); step();
    // R1 reset values
    read_reg(1'b0, v); chk(v == 9'd0, "R1 status", v, 0);
    read_reg(1'b1, v); chk(v == 9'd0, "R1 enable", v, 0);
    chk(!irq && !drop, "R1 irq/drop", {irq, drop}, 0);
    rst_n = 1'b1; step();

    // R2 R8 R9: each event alone
    for (int i = 0; i < 9; i++) begin
      bit ab;
      ab = (i == 2) || (i == 4);
      pulse_evt(9'(1 << i));
      read_reg(1'b0, v);
      chk(v == 9'(1 << i), "R2 set", v, 1 << i);
      chk(drop == ab, ab ? "R8 abort raises drop" : "R9 no drop", drop, ab);
      step(); step();
      read_reg(1'b0, v);
      chk(v == 9'(1 << i), "R2 sticky", v, 1 << i);
      chk(drop == ab, "R8 drop held", drop, ab);
      // R10 start clears
      pkt_start = 1'b1; step(); pkt_start = 1'b0;
      chk(!drop, "R10 start clears", drop, 0);
      // R3 clear with zeros elsewhere untouched, then write 1
      wr(1'b0, ~9'(1 << i));
      read_reg(1'b0, v);
      chk(v == 9'(1 << i), "R3 zero keeps", v, 1 << i);
      wr(1'b0, 9'(1 << i));
      read_reg(1'b0, v);
      chk(v == 9'd0, "R3 one clears", v, 0);
    end

    // R4 set wins over clear, per bit
    for (int i = 0; i < 9; i++) begin
      pulse_evt(9'(1 << i));
      evt_in = 9'(1 << i); reg_we = 1'b1; reg_addr = 1'b0; reg_wdata = 9'h1FF;
      step(); evt_in = '0; reg_we = 1'b0;
      read_reg(1'b0, v);
      chk(v == 9'(1 << i), "R4 set beats clear", v, 1 << i);
      wr(1'b0, 9'h1FF);
    end
    pkt_start = 1'b1; step(); pkt_start = 1'b0;

    // R10 start and abort in same cycle
    evt_in = 9'h010; pkt_start = 1'b1; step(); evt_in = '0; pkt_start = 1'b0;
    chk(drop, "R10 abort beats start", drop, 1);
    pkt_start = 1'b1; step(); pkt_start = 1'b0;
    chk(!drop, "R10 later start clears", drop, 0);
    wr(1'b0, 9'h1FF);

    // R5 R6 R7: sweep all enable masks against two status patterns
    pats[0] = 9'h155; pats[1] = 9'h0AA;
    for (int p = 0; p < 2; p++) begin
      pulse_evt(pats[p]);
      pkt_start = 1'b1; step(); pkt_start = 1'b0;
      for (int m = 0; m < 512; m++) begin
        wr(1'b1, 9'(m));
        read_reg(1'b1, v);
        if (m % 64 == 0) chk(v == 9'(m), "R5 enable readback", v, m);
        read_reg(1'b0, v);
        if (m % 64 == 0) chk(v == pats[p], "R6 status readback", v, pats[p]);
        chk(irq == ((pats[p] & 9'(m)) != 0), "R7 irq", irq, (pats[p] & 9'(m)) != 0);
      end
      wr(1'b0, 9'h1FF);
    end
    wr(1'b1, 9'h000);

    // R11 stream gating across all valid/ready combinations, both drop states
    for (int d = 0; d < 2; d++) begin
      if (d == 1) pulse_evt(9'h004);
      for (int c = 0; c < 4; c++) begin
        in_valid = c[0]; out_ready = c[1]; in_data = 8'(8'h3C + c); pkt_end = c[0];
        #1;
        if (d == 0) begin
          chk(out_valid == c[0] && in_ready == c[1] && out_data == 8'(8'h3C + c)
              && out_last == c[0], "R11 passthrough",
              {out_valid, in_ready, out_data}, {c[0], c[1], 8'(8'h3C + c)});
        end else begin
          chk(!out_valid && in_ready, "R11 discard", {out_valid, in_ready}, 2'b01);
        end
      end
      in_valid = 1'b0; out_ready = 1'b0; pkt_end = 1'b0;
    end

    // R1 again after reset from a busy state
    wr(1'b1, 9'h1FF);
    pulse_evt(9'h1FF);
    restart();
    read_reg(1'b0, v); chk(v == 9'd0, "R1 status after reset", v, 0);
    chk(!irq && !drop, "R1 irq/drop after reset", {irq, drop}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule